// File: doc/BRIEF.md
# Dual Wide Multiply-Accumulate Accumulator Unit

This block holds two independent 72-bit accumulators for a DSP datapath. Each accumulator has a 64-bit body with an 8-bit signed guard field above it. One operation code selects the work for the cycle. The block can multiply two 32-bit operands and add the product to the chosen accumulator, subtract it, or replace the accumulator with it. It can also overwrite one slice of an accumulator, or read one slice back. The operands come from an external register file. Decoding the instruction and updating flags happen outside the block.

A product is formed in one of two ways. It can come from a signed pair of 16-bit halfwords, and that 32-bit product is positioned 16 bits up. Or it can be the full signed 32x32 product with no shift. Accumulation runs across all 72 bits, so a carry or borrow out of the body reaches the guard. A read can shift the body left by up to three bits before the slice is taken. A guard read returns the guard sign-extended to 32 bits. When the read is shifted, the body's top bits fill the low end of that result.

The operation code `op_i` has 5 bits. Bits [4:2] give the kind and bits [1:0] give the form. Operations and reads both take effect at one rising clock edge.

Top module: `dsp_acc_unit`

## Requirements
- R1: While `rst_n` is low, both accumulators clear to zero and `rd_data_o` reads 0. After reset is released, every slice of both accumulators reads 0.
- R2: The halfword multiply forms work as follows. Form 0 multiplies the upper halves of `src_a_i` and `src_b_i`. Form 1 multiplies the lower halves of both. Form 2 multiplies the lower half of `src_a_i` by the upper half of `src_b_i`. The halves are signed 16-bit values, and the 32-bit product is shifted left by 16.
- R3: Form 3 uses the full signed 32x32 product of `src_a_i` and `src_b_i` with no shift.
- R4: Multiply-add (kind 1, op 4..7) adds the sign-extended product to the selected 72-bit accumulator. A carry out of the body increments the guard, and the guard wraps at 8 bits.
- R5: When a multiply-add has a negative product that wraps the body below zero, the guard is decremented.
- R6: Multiply-subtract (kind 2, op 8..11) subtracts the product from the selected accumulator. The borrow out of the body adjusts the guard, and the guard stays an 8-bit value.
- R7: Multiply-replace (kind 3, op 12..15) loads the product into the body. It sets the guard to 0xFF if the product is negative and to 0x00 otherwise.
- R8: Read (kind 5) form 0 (op 20) returns bits 63:32 of the body shifted left by `shift_i`. Form 1 (op 21) returns bits 47:16 and form 2 (op 22) returns bits 31:0, both after the same shift.
- R9: Read form 3 (op 23) returns the guard sign-extended to 32 bits and shifted left by `shift_i`. The top `shift_i` bits of the body fill the vacated low bits.
- R10: Write (kind 4) op 16 replaces body bits 63:32 with `src_a_i`. Op 17 replaces bits 31:0, and op 18 replaces the guard with `src_a_i[7:0]`. All other fields stay unchanged.
- R11: `acc_sel_i` selects accumulator 0 or 1. An operation never changes the accumulator that is not selected.
- R12: A read result appears on `rd_data_o` after the rising edge at which the read is issued, and it holds until the next read. An update is visible to a read issued in the very next cycle.
- R13: Op codes 0..3, op 19 and op 24..31 change neither accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| op_i | input | 5 | Operation: kind in [4:2], form in [1:0] |
| acc_sel_i | input | 1 | Accumulator select |
| src_a_i | input | 32 | First operand; write data for slice writes |
| src_b_i | input | 32 | Second operand |
| shift_i | input | 2 | Left shift applied to the body for reads |
| rd_data_o | output | 32 | Registered read result |

## Verification
Every accumulator update takes effect at the rising edge at which the operation is presented. A read presented at the next edge shows the result on `rd_data_o`, so a result is due one edge after its read is issued and two edges after the update it observes. The bench drives each operation at a falling edge and samples 1 ns after the following rising edge. It therefore sees each read result in the first cycle it is valid. One directed check looks at the output before the read edge, to confirm the result has not arrived early. Another confirms the output holds through operations that are not reads.

// File: rtl/dsp_acc_pkg.sv
package dsp_acc_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned HALF_W  = DATA_W / 2;
  localparam int unsigned BODY_W  = 2 * DATA_W;
  localparam int unsigned GUARD_W = 8;
  localparam int unsigned ACC_W   = BODY_W + GUARD_W;
  localparam int unsigned N_ACC   = 2;
  localparam int unsigned SEL_W   = (N_ACC > 1) ? $clog2(N_ACC) : 1;
  localparam int unsigned OP_W    = 5;
  localparam int unsigned SHIFT_W = 2;

  typedef enum logic [2:0] {
    K_NOP  = 3'd0,
    K_MAC  = 3'd1,
    K_MSB  = 3'd2,
    K_MUL  = 3'd3,
    K_WR   = 3'd4,
    K_RD   = 3'd5,
    K_RSV6 = 3'd6,
    K_RSV7 = 3'd7
  } kind_e;

  // operand forms for multiply kinds
  localparam logic [1:0] F_HH = 2'd0;
  localparam logic [1:0] F_LL = 2'd1;
  localparam logic [1:0] F_LH = 2'd2;
  localparam logic [1:0] F_W  = 2'd3;
  // slice codes for writes
  localparam logic [1:0] W_HI = 2'd0;
  localparam logic [1:0] W_LO = 2'd1;
  localparam logic [1:0] W_GU = 2'd2;
  // slice codes for reads
  localparam logic [1:0] R_HI = 2'd0;
  localparam logic [1:0] R_MI = 2'd1;
  localparam logic [1:0] R_LO = 2'd2;
  localparam logic [1:0] R_GU = 2'd3;

  typedef struct packed {
    logic [GUARD_W-1:0] guard;
    logic [BODY_W-1:0]  body;
  } acc_t;

endpackage

// File: rtl/dsp_acc_mul.sv
module dsp_acc_mul
  import dsp_acc_pkg::*;
(
  input  logic [1:0]              form_i,
  input  logic [DATA_W-1:0]       a_i,
  input  logic [DATA_W-1:0]       b_i,
  output logic signed [ACC_W-1:0] addend_o
);

  logic signed [HALF_W-1:0] half_a;
  logic signed [HALF_W-1:0] half_b;
  logic signed [DATA_W-1:0] half_prod;
  logic signed [DATA_W-1:0] word_a;
  logic signed [DATA_W-1:0] word_b;
  logic signed [BODY_W-1:0] word_prod;

  always_comb begin
    // only the high-by-high form takes the upper half of operand a
    half_a    = (form_i == F_HH) ? a_i[DATA_W-1 -: HALF_W] : a_i[HALF_W-1:0];
    // only the low-by-low form takes the lower half of operand b
    half_b    = (form_i == F_LL) ? b_i[HALF_W-1:0] : b_i[DATA_W-1 -: HALF_W];
    half_prod = DATA_W'(half_a) * DATA_W'(half_b);
    word_a    = a_i;
    word_b    = b_i;
    word_prod = BODY_W'(word_a) * BODY_W'(word_b);
    if (form_i == F_W) begin
      addend_o = ACC_W'(word_prod);
    end else begin
      addend_o = ACC_W'(half_prod) <<< HALF_W;
    end
  end

endmodule

// File: rtl/dsp_acc_bank.sv
module dsp_acc_bank
  import dsp_acc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  kind_e                    kind_i,
  input  logic [1:0]               form_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic signed [ACC_W-1:0]  addend_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output acc_t [N_ACC-1:0]         acc_o
);

  acc_t [N_ACC-1:0] acc_q;
  acc_t [N_ACC-1:0] acc_d;
  logic [N_ACC-1:0] acc_en;
  logic             op_updates;

  always_comb begin
    unique case (kind_i)
      K_MAC, K_MSB, K_MUL: op_updates = 1'b1;
      K_WR:                op_updates = (form_i != 2'd3);
      default:             op_updates = 1'b0;
    endcase
  end

  for (genvar i = 0; i < N_ACC; i++) begin : g_acc
    // next-state for one accumulator
    always_comb begin
      acc_en[i] = op_updates && (sel_i == SEL_W'(i));
      acc_d[i]  = acc_q[i];
      unique case (kind_i)
        K_MAC: acc_d[i] = acc_t'(ACC_W'(acc_q[i]) + ACC_W'(addend_i));
        K_MSB: acc_d[i] = acc_t'(ACC_W'(acc_q[i]) - ACC_W'(addend_i));
        K_MUL: acc_d[i] = acc_t'(addend_i);
        K_WR: begin
          unique case (form_i)
            W_HI:    acc_d[i].body[BODY_W-1 -: DATA_W] = wdata_i;
            W_LO:    acc_d[i].body[DATA_W-1:0]         = wdata_i;
            W_GU:    acc_d[i].guard                    = wdata_i[GUARD_W-1:0];
            default: acc_d[i] = acc_q[i];
          endcase
        end
        default: acc_d[i] = acc_q[i];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[i] <= '0;
      end else if (acc_en[i]) begin
        acc_q[i] <= acc_d[i];
      end
    end

    // R11: an operation aimed at the other accumulator leaves this one alone
    a_r11_other_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i != SEL_W'(i)) |=> $stable(acc_q[i]));

    // R7: replace leaves the guard as the sign of the body
    a_r7_replace_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == K_MUL && sel_i == SEL_W'(i)) |=>
        (acc_q[i].guard == {GUARD_W{acc_q[i].body[BODY_W-1]}}));

    // R4, R5, R6: a 64-bit product moves the guard by at most one step
    a_r4_guard_step: assert property (@(posedge clk) disable iff (!rst_n)
      ((kind_i == K_MAC || kind_i == K_MSB) && sel_i == SEL_W'(i)) |=>
        ((acc_q[i].guard == $past(acc_q[i].guard)) ||
         (acc_q[i].guard == $past(acc_q[i].guard) + GUARD_W'(1)) ||
         (acc_q[i].guard == $past(acc_q[i].guard) - GUARD_W'(1))));

    // R10: a low-word write keeps the upper body and the guard
    a_r10_wr_lo_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == K_WR && form_i == W_LO && sel_i == SEL_W'(i)) |=>
        ($stable(acc_q[i].guard) && $stable(acc_q[i].body[BODY_W-1 -: DATA_W])));

    // R13: reserved codes touch nothing
    a_r13_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == K_NOP || kind_i == K_RSV6 || kind_i == K_RSV7 ||
       (kind_i == K_WR && form_i == 2'd3)) |=> $stable(acc_q[i]));
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/dsp_acc_rdsel.sv
module dsp_acc_rdsel
  import dsp_acc_pkg::*;
(
  input  acc_t                acc_i,
  input  logic [1:0]          form_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  output logic [DATA_W-1:0]   rd_o
);

  localparam int unsigned WIDE_W = BODY_W + DATA_W;

  logic [BODY_W-1:0] body_sh;
  logic [WIDE_W-1:0] guard_wide;
  logic [WIDE_W-1:0] guard_sh;

  always_comb begin
    body_sh    = acc_i.body << shift_i;
    // guard sign-extended above the body; shifting the pair pulls body top bits in
    guard_wide = {{(DATA_W-GUARD_W){acc_i.guard[GUARD_W-1]}}, acc_i.guard, acc_i.body};
    guard_sh   = guard_wide << shift_i;
    unique case (form_i)
      R_HI:    rd_o = body_sh[BODY_W-1 -: DATA_W];
      R_MI:    rd_o = body_sh[BODY_W-1-HALF_W -: DATA_W];
      R_LO:    rd_o = body_sh[DATA_W-1:0];
      default: rd_o = guard_sh[WIDE_W-1 -: DATA_W];
    endcase
  end

endmodule

// File: rtl/dsp_acc_unit.sv
module dsp_acc_unit
  import dsp_acc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OP_W-1:0]      op_i,
  input  logic                 acc_sel_i,
  input  logic [DATA_W-1:0]    src_a_i,
  input  logic [DATA_W-1:0]    src_b_i,
  input  logic [SHIFT_W-1:0]   shift_i,
  output logic [DATA_W-1:0]    rd_data_o
);

  kind_e                    kind;
  logic [1:0]               form;
  logic [SEL_W-1:0]         sel;
  logic signed [ACC_W-1:0]  addend;
  acc_t [N_ACC-1:0]         acc_vec;
  logic [DATA_W-1:0]        rd_sel;
  logic [DATA_W-1:0]        rd_d;
  logic [DATA_W-1:0]        rd_q;

  assign kind = kind_e'(op_i[4:2]);
  assign form = op_i[1:0];
  assign sel  = SEL_W'(acc_sel_i);

  dsp_acc_mul u_mul (
    .form_i   (form),
    .a_i      (src_a_i),
    .b_i      (src_b_i),
    .addend_o (addend)
  );

  dsp_acc_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind_i   (kind),
    .form_i   (form),
    .sel_i    (sel),
    .addend_i (addend),
    .wdata_i  (src_a_i),
    .acc_o    (acc_vec)
  );

  dsp_acc_rdsel u_rdsel (
    .acc_i   (acc_vec[sel]),
    .form_i  (form),
    .shift_i (shift_i),
    .rd_o    (rd_sel)
  );

  always_comb begin
    rd_d = rd_q;
    if (kind == K_RD) begin
      rd_d = rd_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data_o = rd_q;

  // R12: the read port holds between reads
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != K_RD) |=> $stable(rd_data_o));

  // R8: an unshifted low-word read returns the live low body bits
  a_r8_lo_read: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_RD && form == R_LO && shift_i == '0) |=>
      (rd_data_o == $past(acc_vec[sel].body[DATA_W-1:0])));

endmodule

// File: tb/dsp_acc_unit_tb.sv
`timescale 1ns/1ps
module dsp_acc_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op_i = '0;
  logic        acc_sel_i = 1'b0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic [1:0]  shift_i = '0;
  logic [31:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dsp_acc_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .acc_sel_i (acc_sel_i),
    .src_a_i   (src_a_i),
    .src_b_i   (src_b_i),
    .shift_i   (shift_i),
    .rd_data_o (rd_data_o)
  );

  // op codes: kind in [4:2], form in [1:0]
  localparam logic [4:0] OP_NOP = 5'd0;
  localparam logic [4:0] MAC_HH = 5'd4,  MAC_W = 5'd7;
  localparam logic [4:0] MSB_LL = 5'd9,  MSB_W = 5'd11;
  localparam logic [4:0] MUL_HH = 5'd12, MUL_LL = 5'd13, MUL_LH = 5'd14, MUL_W = 5'd15;
  localparam logic [4:0] WR_HI = 5'd16, WR_LO = 5'd17, WR_GU = 5'd18, WR_RSV = 5'd19;
  localparam logic [4:0] RD_HI = 5'd20, RD_MI = 5'd21, RD_LO = 5'd22, RD_GU = 5'd23;

  typedef struct packed {
    logic [4:0]  op;
    logic        sel;
    logic [1:0]  sh;
    logic [31:0] a;
    logic [31:0] b;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{MUL_W,  1'b0, 2'd0, 32'h00000003, 32'hFFFFFFFE, 1'b0, 32'h0,        4'd7 },  // R7 -6
    '{RD_GU,  1'b0, 2'd0, 32'h0,        32'h0,        1'b1, 32'hFFFFFFFF, 4'd7 },  // R7
    '{RD_LO,  1'b0, 2'd0, 32'h0,        32'h0,        1'b1, 32'hFFFFFFFA, 4'd3 },  // R3
    '{RD_HI,  1'b0, 2'd0, 32'h0,        32'h0,        1'b1, 32'hFFFFFFFF, 4'd3 },  // R3
    '{MAC_W,  1'b0, 2'd0, 32'h00000001, 32'h0000000A, 1'b0, 32'h0,        4'd4 },  // R4 carry
    '{RD_GU,  1'b0, 2'd0, 32'h0,        32'h0,        1'b1, 32'h00000000, 4'd4 },  // R4
    '{RD_LO,  1'b0, 2'd0, 32'h0,        32'h0,        1'b1, 32'h00000004, 4'd4 },  // R4
    '{MSB_W,  1'b0, 2'd0, 32'h00000001, 32'h00000005, 1'b0, 32'h0,        4'd6 },  // R6 borrow
    '{RD_GU,  1'b0, 2'd0, 32'h0,        32'h0,        1'b1, 32'hFFFFFFFF, 4'd6 },  // R6
    '{RD_HI,  1'b0, 2'd0, 32'h0,        32'h0,        1'b1, 32'hFFFFFFFF, 4'd6 },  // R6
    '{MUL_HH, 1'b1, 2'd0, 32'h00031234, 32'hFFFE5678, 1'b0, 32'h0,        4'd2 },  // R2 hi*hi
    '{RD_LO,  1'b1, 2'd0, 32'h0,        32'h0,        1'b1, 32'hFFFA0000, 4'd2 },  // R2
    '{RD_MI,  1'b1, 2'd0, 32'h0,        32'h0,        1'b1, 32'hFFFFFFFA, 4'd8 },  // R8
    '{MUL_LL, 1'b1, 2'd0, 32'h7FFF8000, 32'h12348000, 1'b0, 32'h0,        4'd2 },  // R2 lo*lo
    '{RD_HI,  1'b1, 2'd0, 32'h0,        32'h0,        1'b1, 32'h00004000, 4'd2 },  // R2
    '{RD_HI,  1'b1, 2'd2, 32'h0,        32'h0,        1'b1, 32'h00010000, 4'd8 },  // R8 shift 2
    '{MUL_LH, 1'b1, 2'd0, 32'hAAAA0002, 32'h0005BBBB, 1'b0, 32'h0,        4'd2 },  // R2 lo*hi
    '{RD_LO,  1'b1, 2'd0, 32'h0,        32'h0,        1'b1, 32'h000A0000, 4'd2 },  // R2
    '{RD_MI,  1'b1, 2'd1, 32'h0,        32'h0,        1'b1, 32'h00000014, 4'd8 },  // R8 shift 1
    '{RD_LO,  1'b0, 2'd0, 32'h0,        32'h0,        1'b1, 32'hFFFFFFFF, 4'd11},  // R11 acc0 kept
    '{MAC_HH, 1'b1, 2'd0, 32'h00020000, 32'h00030000, 1'b0, 32'h0,        4'd4 },  // R4 halfword add
    '{RD_LO,  1'b1, 2'd0, 32'h0,        32'h0,        1'b1, 32'h00100000, 4'd4 },  // R4
    '{MSB_LL, 1'b1, 2'd0, 32'h00000001, 32'h00000010, 1'b0, 32'h0,        4'd6 },  // R6 to zero
    '{RD_LO,  1'b1, 2'd0, 32'h0,        32'h0,        1'b1, 32'h00000000, 4'd6 },  // R6
    '{RD_GU,  1'b1, 2'd0, 32'h0,        32'h0,        1'b1, 32'h00000000, 4'd6 }   // R6
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns after the rising edge
  task automatic issue(input logic [4:0] op, input logic sel, input logic [31:0] a,
                       input logic [31:0] b, input logic [1:0] sh);
    @(negedge clk);
    op_i = op; acc_sel_i = sel; src_a_i = a; src_b_i = b; shift_i = sh;
    @(posedge clk);
    #1;
    op_i = OP_NOP;
  endtask

  task automatic rd(input int req, input logic [4:0] op, input logic sel,
                    input logic [1:0] sh, input logic [31:0] exp);
    issue(op, sel, 32'h0, 32'h0, sh);
    check(req, rd_data_o, exp);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, rd_data_o, 32'h0);             // R1 during reset
    rst_n = 1'b1;
    for (int s = 0; s < 2; s++) begin       // R1 all slices zero
      rd(1, RD_HI, s[0], 2'd0, 32'h0);
      rd(1, RD_LO, s[0], 2'd0, 32'h0);
      rd(1, RD_GU, s[0], 2'd0, 32'h0);
    end

    for (int k = 0; k < NV; k++) begin
      issue(TBL[k].op, TBL[k].sel, TBL[k].a, TBL[k].b, TBL[k].sh);
      if (TBL[k].chk) check(int'(TBL[k].req), rd_data_o, TBL[k].exp);
    end

    // R10 slice writes keep the other fields
    issue(WR_HI, 1'b0, 32'h12345678, 32'h0, 2'd0);
    issue(WR_LO, 1'b0, 32'h9ABCDEF0, 32'h0, 2'd0);
    issue(WR_GU, 1'b0, 32'hFFFF00A5, 32'h0, 2'd0);
    rd(10, RD_HI, 1'b0, 2'd0, 32'h12345678);
    rd(10, RD_MI, 1'b0, 2'd0, 32'h56789ABC);
    rd(10, RD_GU, 1'b0, 2'd0, 32'hFFFFFFA5);
    issue(WR_HI, 1'b0, 32'hCAFEBABE, 32'h0, 2'd0);
    rd(10, RD_LO, 1'b0, 2'd0, 32'h9ABCDEF0);
    rd(10, RD_GU, 1'b0, 2'd0, 32'hFFFFFFA5);
    issue(WR_GU, 1'b0, 32'h00000001, 32'h0, 2'd0);
    rd(10, RD_HI, 1'b0, 2'd0, 32'hCAFEBABE);

    // R9 shifted guard read pulls in body top bits (110...)
    rd(9, RD_GU, 1'b0, 2'd1, 32'h00000003);
    rd(9, RD_GU, 1'b0, 2'd2, 32'h00000007);
    rd(9, RD_GU, 1'b0, 2'd3, 32'h0000000E);

    // R13 reserved codes change nothing
    issue(WR_RSV, 1'b0, 32'h0, 32'h0, 2'd0);
    issue(5'd26, 1'b0, 32'h1, 32'h1, 2'd0);
    issue(5'd2, 1'b0, 32'h1, 32'h1, 2'd0);
    rd(13, RD_HI, 1'b0, 2'd0, 32'hCAFEBABE);
    rd(13, RD_LO, 1'b0, 2'd0, 32'h9ABCDEF0);
    rd(13, RD_GU, 1'b0, 2'd0, 32'h00000001);

    // R4 guard wraps 7F -> 80 on carry; R6 borrow brings it back
    issue(WR_GU, 1'b0, 32'h0000007F, 32'h0, 2'd0);
    issue(WR_HI, 1'b0, 32'hFFFFFFFF, 32'h0, 2'd0);
    issue(WR_LO, 1'b0, 32'hFFFFFFFF, 32'h0, 2'd0);
    issue(MAC_W, 1'b0, 32'h1, 32'h1, 2'd0);
    rd(4, RD_GU, 1'b0, 2'd0, 32'hFFFFFF80);
    rd(4, RD_HI, 1'b0, 2'd0, 32'h00000000);
    issue(MSB_W, 1'b0, 32'h1, 32'h1, 2'd0);
    rd(6, RD_GU, 1'b0, 2'd0, 32'h0000007F);
    rd(6, RD_LO, 1'b0, 2'd0, 32'hFFFFFFFF);

    // R5 negative addend wraps the body below zero
    issue(WR_GU, 1'b0, 32'h0, 32'h0, 2'd0);
    issue(WR_HI, 1'b0, 32'h0, 32'h0, 2'd0);
    issue(WR_LO, 1'b0, 32'h0, 32'h0, 2'd0);
    issue(MAC_W, 1'b0, 32'h00000001, 32'hFFFFFFFF, 2'd0);
    rd(5, RD_GU, 1'b0, 2'd0, 32'hFFFFFFFF);
    rd(5, RD_LO, 1'b0, 2'd0, 32'hFFFFFFFF);

    // R12 hold through non-reads, then latency of a read
    issue(MAC_W, 1'b0, 32'h1, 32'h1, 2'd0);
    issue(WR_LO, 1'b0, 32'h11111111, 32'h0, 2'd0);
    check(12, rd_data_o, 32'hFFFFFFFF);
    @(negedge clk);
    op_i = RD_LO; acc_sel_i = 1'b0; shift_i = 2'd0;
    #1;
    check(12, rd_data_o, 32'hFFFFFFFF);     // not yet due
    @(posedge clk);
    #1;
    op_i = OP_NOP;
    check(12, rd_data_o, 32'h11111111);     // due one edge after issue

    finish_run();
  end

endmodule